// File: doc/BRIEF.md
# Alert Response Responder for a Two-Wire Management Bus

This block is the device-side half of the bus alert mechanism. A local event raises a one-cycle request pulse. The block then pulls the shared, active-low, open-drain alert line. The host services the alert by reading from the reserved alert response address. The block watches the already-synchronised clock and data lines and recognises such a read. It acknowledges the address byte. It then returns its own 7-bit address as the data byte, most significant bit first.

Several devices may have an alert pending at the same time. The block therefore arbitrates bit by bit while it transmits. It releases the data line for a 1, and if it then samples a 0 it falls silent for the rest of the byte. Only a device that sends its whole address without losing releases its alert output. A device that loses keeps the alert asserted and competes again on the host's next alert response read.

Top module: `smbAlertResp`

## Requirements
- R1: While reset is asserted, neither the data line nor the alert line is pulled low (`sdaDrvLow` = 0, `alertDrvLow` = 0).
- R2: A one-cycle `alertReq` pulse causes `alertDrvLow` to be 1 from the next clock edge on, and it stays 1 until the block wins an alert response read.
- R3: The block acknowledges an address byte only when all three of these hold: the byte is the 7-bit address 0x0C followed by a read bit of 1 (byte value 0x19), MSB first; the alert is pending; and the byte follows a START. It acknowledges by pulling SDA low during the ninth clock. For any other address, a write bit of 0, or no pending alert, it leaves SDA released for the whole transaction.
- R4: In the data byte after its acknowledge, the block sends its own address in bits 7..1, MSB first, and sends bit 0 as 0.
- R5: `sdaDrvLow` changes only while SCL is low.
- R6: Arbitration loss works as follows. If the block leaves SDA released for a 1 and samples 0 on a rising SCL, it stops driving for the rest of that byte, and `alertDrvLow` stays 1.
- R7: A block that sends all eight data bits without losing arbitration releases `alertDrvLow` right after the eighth rising SCL of the data byte.
- R8: A block that lost arbitration answers the next alert response read again, and wins it if no lower address competes.
- R9: A request that arrives while the alert is already pending is absorbed. One won read releases the alert, and a further alert response read is not acknowledged.
- R10: START (SDA falling while SCL is high) restarts address reception from any state. STOP (SDA rising while SCL is high) returns the block to idle. An aborted or interrupted transaction therefore does not disturb the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| alertReq | input | 1 | One-cycle request to raise an alert |
| ownAddr | input | ADDR_W | Device address returned during the alert response |
| sclIn | input | 1 | Synchronised bus clock level |
| sdaIn | input | 1 | Synchronised bus data level |
| sdaDrvLow | output | 1 | 1 pulls the data line low (open-drain enable) |
| alertDrvLow | output | 1 | 1 pulls the shared alert line low (open-drain enable) |

## Verification
The hardest situation to reach is a loss of arbitration partway through the returned byte, followed by a win on the retry. No single device can produce this from its own ports. The bench therefore models a second alerting responder on the wired-AND data line. This rival drives its own address and applies the same loss rule as the block. Directed cases place the rival's address below, above and equal to the block's address, and random iterations vary both addresses, whether the rival is present, and doubled requests. A losing iteration is always followed by a retry read that must release the alert.

// File: rtl/smbAlertPkg.sv
package smbAlertPkg;

  // Strobes from the controller to the datapath
  typedef struct packed {
    logic cntClr;
    logic bitTick;
    logic txLoad;
    logic txShift;
    logic lostClr;
    logic lostCheck;
  } dpCtrl_t;

  // Bus events decoded by the datapath
  typedef struct packed {
    logic start;
    logic stop;
    logic sclRise;
    logic sclFall;
  } busEv_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_PRE,
    ST_ACK_HOLD,
    ST_SEND,
    ST_SEND_END,
    ST_IGNORE
  } respState_t;

endpackage

// File: rtl/smbAlertDp.sv
module smbAlertDp
  import smbAlertPkg::*;
#(
  parameter int ADDR_W = 7,
  parameter logic [ADDR_W-1:0] ARA_ADDR = 'h0C
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [ADDR_W-1:0] ownAddr,
  input  dpCtrl_t           ctl,
  output busEv_t            ev,
  output logic              lastBit,
  output logic              rxMatch,
  output logic              txBit,
  output logic              lost,
  output logic              loseNow
);
  localparam int BYTE_W = ADDR_W + 1;
  localparam int CNT_W  = $clog2(BYTE_W);

  logic              sclQ, sdaQ;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] rxSh;
  logic [BYTE_W-1:0] txSh;
  logic              lostQ;

  always_comb begin
    ev.sclRise = sclIn & ~sclQ;
    ev.sclFall = ~sclIn & sclQ;
    ev.start   = sclIn & sclQ & sdaQ & ~sdaIn;
    ev.stop    = sclIn & sclQ & ~sdaQ & sdaIn;
  end

  assign lastBit = (cnt == CNT_W'(BYTE_W - 1));
  assign rxMatch = ({rxSh, sdaIn} == {ARA_ADDR, 1'b1});
  assign txBit   = txSh[BYTE_W-1];
  assign lost    = lostQ;
  // released for a one while someone else holds the line low
  assign loseNow = txBit & ~sdaIn & ~lostQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclQ  <= 1'b1;
      sdaQ  <= 1'b1;
      cnt   <= '0;
      rxSh  <= '0;
      txSh  <= '1;
      lostQ <= 1'b0;
    end else begin
      sclQ <= sclIn;
      sdaQ <= sdaIn;
      if (ctl.cntClr)       cnt <= '0;
      else if (ctl.bitTick) cnt <= cnt + 1'b1;
      if (ctl.bitTick)      rxSh <= {rxSh[ADDR_W-2:0], sdaIn};
      if (ctl.txLoad)       txSh <= {ownAddr, 1'b0};
      else if (ctl.txShift) txSh <= {txSh[BYTE_W-2:0], 1'b1};
      if (ctl.lostClr)                   lostQ <= 1'b0;
      else if (ctl.lostCheck && loseNow) lostQ <= 1'b1;
    end
  end

endmodule

// File: rtl/smbAlertCtrl.sv
module smbAlertCtrl
  import smbAlertPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    alertReq,
  input  busEv_t  ev,
  input  logic    lastBit,
  input  logic    rxMatch,
  input  logic    txBit,
  input  logic    lost,
  input  logic    loseNow,
  output dpCtrl_t ctl,
  output logic    sdaDrvLow,
  output logic    alertDrvLow
);
  respState_t state, nextState;
  logic       alertQ;
  logic       win;

  always_comb begin
    nextState = state;
    ctl       = '0;
    win       = 1'b0;
    if (ev.start) begin
      nextState  = ST_ADDR;
      ctl.cntClr = 1'b1;
    end else if (ev.stop) begin
      nextState = ST_IDLE;
    end else begin
      case (state)
        ST_IDLE, ST_IGNORE: nextState = state;
        ST_ADDR:
          if (ev.sclRise) begin
            ctl.bitTick = 1'b1;
            if (lastBit) nextState = (rxMatch && alertQ) ? ST_ACK_PRE : ST_IGNORE;
          end
        ST_ACK_PRE:
          if (ev.sclFall) nextState = ST_ACK_HOLD;
        ST_ACK_HOLD:
          if (ev.sclFall) begin
            nextState   = ST_SEND;
            ctl.txLoad  = 1'b1;
            ctl.cntClr  = 1'b1;
            ctl.lostClr = 1'b1;
          end
        ST_SEND:
          if (ev.sclRise) begin
            ctl.bitTick   = 1'b1;
            ctl.lostCheck = 1'b1;
            if (lastBit) begin
              nextState = ST_SEND_END;
              win       = ~lost & ~loseNow;
            end
          end else if (ev.sclFall) begin
            ctl.txShift = 1'b1;
          end
        ST_SEND_END:
          if (ev.sclFall) nextState = ST_IGNORE;
        default: nextState = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      alertQ <= 1'b0;
    end else begin
      state  <= nextState;
      alertQ <= alertReq | (alertQ & ~win);
    end
  end

  assign alertDrvLow = alertQ;
  assign sdaDrvLow   = (state == ST_ACK_HOLD) ||
                       (((state == ST_SEND) || (state == ST_SEND_END)) && !txBit && !lost);

endmodule

// File: rtl/smbAlertResp.sv
module smbAlertResp
  import smbAlertPkg::*;
#(
  parameter int ADDR_W = 7,
  parameter logic [ADDR_W-1:0] ARA_ADDR = 'h0C
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              alertReq,
  input  logic [ADDR_W-1:0] ownAddr,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaDrvLow,
  output logic              alertDrvLow
);
  dpCtrl_t ctl;
  busEv_t  ev;
  logic    lastBit, rxMatch, txBit, lost, loseNow;

  smbAlertDp #(.ADDR_W(ADDR_W), .ARA_ADDR(ARA_ADDR)) u_dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .ownAddr(ownAddr),
    .ctl(ctl), .ev(ev), .lastBit(lastBit), .rxMatch(rxMatch), .txBit(txBit),
    .lost(lost), .loseNow(loseNow)
  );

  smbAlertCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .alertReq(alertReq), .ev(ev), .lastBit(lastBit),
    .rxMatch(rxMatch), .txBit(txBit), .lost(lost), .loseNow(loseNow),
    .ctl(ctl), .sdaDrvLow(sdaDrvLow), .alertDrvLow(alertDrvLow)
  );

endmodule

// File: rtl/smbAlertRespChk.sv
module smbAlertRespChk (
  input logic clk,
  input logic rstN,
  input logic alertReq,
  input logic sclIn,
  input logic sdaIn,
  input logic sdaDrvLow,
  input logic alertDrvLow
);
  // R1
  always @(posedge clk) begin
    if (!rstN) begin
      rst_idle_chk: assert (!sdaDrvLow && !alertDrvLow);
    end
  end

  // R2
  req_raise_chk: assert property (@(posedge clk) disable iff (!rstN)
    alertReq |=> alertDrvLow);

  // R5
  sda_low_phase_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sdaDrvLow != $past(sdaDrvLow)) |-> (!sclIn && !$past(sclIn)));

  // R7
  release_after_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(alertDrvLow) |-> ($past(sdaDrvLow) && $past(sclIn)));

  // R10
  start_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sclIn && $past(sclIn) && $past(sdaIn) && !sdaIn) |=> !sdaDrvLow);

endmodule

bind smbAlertResp smbAlertRespChk u_chk (
  .clk(clk), .rstN(rstN), .alertReq(alertReq), .sclIn(sclIn), .sdaIn(sdaIn),
  .sdaDrvLow(sdaDrvLow), .alertDrvLow(alertDrvLow)
);

// File: tb/smbAlertResp_tb.sv
module smbAlertResp_tb;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rstN = 1'b1;
  logic alertReq = 1'b0;
  logic [6:0] ownAddr = 7'h2A;
  logic scl = 1'b1;
  logic mSda = 1'b1;
  logic rivalLow = 1'b0;
  logic sdaDrvLow, alertDrvLow;
  logic sdaLine;
  int total = 0;
  int bad = 0;
  int edgeViol = 0;
  logic prevDrv = 1'b0;

  always #10 clk = ~clk;
  assign sdaLine = mSda & ~sdaDrvLow & ~rivalLow;

  smbAlertResp u_dut (
    .clk(clk), .rstN(rstN), .alertReq(alertReq), .ownAddr(ownAddr),
    .sclIn(scl), .sdaIn(sdaLine), .sdaDrvLow(sdaDrvLow), .alertDrvLow(alertDrvLow)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expByte(input logic [6:0] own, input bit rivOn,
                                         input logic [6:0] riv);
    if (rivOn && riv < own) return {riv, 1'b0};
    return {own, 1'b0};
  endfunction

  function automatic bit dutWins(input logic [6:0] own, input bit rivOn, input logic [6:0] riv);
    return !rivOn || (own <= riv);
  endfunction

  // R5 monitor: drive changes only seen with SCL low
  always @(negedge clk) begin
    if (rstN && (sdaDrvLow != prevDrv) && scl) edgeViol++;
    prevDrv <= sdaDrvLow;
  end

  task automatic pulseReq();
    alertReq = 1'b1;
    tick(1);
    alertReq = 1'b0;
    tick(1);
  endtask

  task automatic busStart();
    mSda = 1'b1; scl = 1'b1; tick(HALF);
    mSda = 1'b0; tick(HALF);
    scl = 1'b0; tick(HALF);
  endtask

  task automatic busStop();
    mSda = 1'b0; tick(HALF);
    scl = 1'b1; tick(HALF);
    mSda = 1'b1; tick(HALF);
  endtask

  task automatic clkBit(input bit b, output bit s);
    mSda = b; tick(HALF);
    scl = 1'b1; tick(HALF / 2);
    s = sdaLine; tick(HALF / 2);
    scl = 1'b0;
  endtask

  task automatic dataBit(input bit rivOn, input bit rivBit, inout bit rivLost, output bit s);
    mSda = 1'b1;
    rivalLow = rivOn && !rivLost && !rivBit;
    tick(HALF);
    scl = 1'b1; tick(HALF / 2);
    s = sdaLine;
    if (rivOn && !rivLost && rivBit && !s) rivLost = 1'b1;
    tick(HALF / 2);
    scl = 1'b0; tick(1);
    rivalLow = 1'b0;
  endtask

  task automatic txn(input logic [6:0] addr, input bit rd, input bit rivOn,
                     input logic [6:0] riv, output bit ack, output logic [7:0] data);
    logic [7:0] hdr;
    bit s;
    bit rivLost;
    logic [7:0] rivByte;
    hdr = {addr, rd};
    rivByte = {riv, 1'b0};
    rivLost = 1'b0;
    busStart();
    for (int i = 7; i >= 0; i--) clkBit(hdr[i], s);
    clkBit(1'b1, s);
    ack = !s;
    for (int i = 7; i >= 0; i--) begin
      dataBit(rivOn, rivByte[i], rivLost, s);
      data[i] = s;
    end
    clkBit(1'b1, s);
    busStop();
  endtask

  initial begin
    tick(150000);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit ack;
    logic [7:0] data;
    bit s;
    void'($urandom(32'h5eed1234));
    #5 rstN = 1'b0;
    tick(3);
    chk("R1 sda released in reset", sdaDrvLow, 0);
    chk("R1 alert released in reset", alertDrvLow, 0);
    rstN = 1'b1;
    tick(4);

    // R3: no pending alert -> silent
    txn(7'h0C, 1'b1, 1'b0, 7'h0, ack, data);
    chk("R3 no ack without alert", ack, 0);
    chk("R3 data untouched without alert", data, 8'hFF);

    pulseReq();
    chk("R2 alert raised", alertDrvLow, 1);

    // R3: other address and write direction
    txn(7'h0D, 1'b1, 1'b0, 7'h0, ack, data);
    chk("R3 no ack other address", ack, 0);
    chk("R3 data untouched other address", data, 8'hFF);
    txn(7'h0C, 1'b0, 1'b0, 7'h0, ack, data);
    chk("R3 no ack write bit", ack, 0);
    chk("R2 alert held", alertDrvLow, 1);

    // R10: aborted address then STOP, junk then repeated START
    busStart();
    for (int i = 0; i < 3; i++) clkBit(1'b0, s);
    busStop();
    busStart();
    for (int i = 0; i < 4; i++) clkBit(i[0], s);

    // R6: lower rival wins
    txn(7'h0C, 1'b1, 1'b1, 7'h10, ack, data);
    chk("R6 rival byte on bus", data, expByte(7'h2A, 1'b1, 7'h10));
    chk("R6 alert kept after loss", alertDrvLow, 1);

    // R8, R7, R4: retry alone wins
    txn(7'h0C, 1'b1, 1'b0, 7'h0, ack, data);
    chk("R10 ack after aborted txns", ack, 1);
    chk("R4 own address returned", data, 8'h54);
    chk("R8 alert released on retry", alertDrvLow, 0);

    // R9: double request absorbed
    pulseReq();
    pulseReq();
    txn(7'h0C, 1'b1, 1'b0, 7'h0, ack, data);
    chk("R9 first read acked", ack, 1);
    chk("R9 released after one win", alertDrvLow, 0);
    txn(7'h0C, 1'b1, 1'b0, 7'h0, ack, data);
    chk("R9 second read not acked", ack, 0);

    // R7: higher rival loses to block
    pulseReq();
    txn(7'h0C, 1'b1, 1'b1, 7'h55, ack, data);
    chk("R7 win vs higher rival data", data, 8'h54);
    chk("R7 alert released after win", alertDrvLow, 0);

    // random mix
    for (int it = 0; it < 40; it++) begin
      logic [6:0] own;
      logic [6:0] riv;
      bit rivOn;
      own = 7'($urandom);
      riv = 7'($urandom);
      rivOn = 1'($urandom);
      if (it == 5) begin riv = own; rivOn = 1'b1; end
      ownAddr = own;
      tick(2);
      pulseReq();
      if ($urandom % 3 == 0) pulseReq();
      txn(7'h0C, 1'b1, rivOn, riv, ack, data);
      if (!rivOn) chk("R3 random ack", ack, 1);
      chk("R4 random data", data, expByte(own, rivOn, riv));
      chk("R6 random alert", alertDrvLow, dutWins(own, rivOn, riv) ? 0 : 1);
      if (!dutWins(own, rivOn, riv)) begin
        txn(7'h0C, 1'b1, 1'b0, 7'h0, ack, data);
        chk("R8 random retry data", data, {own, 1'b0});
        chk("R8 random retry alert", alertDrvLow, 0);
      end
    end

    chk("R5 sda changed only with scl low", edgeViol, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule